// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the status byte of a serial non-volatile memory and rules on every write request a serial front end decodes. The front end hands over one decoded command at a time: set write-enable, clear write-enable, write-status with a data byte, or array write with an address. The block answers each one with a one-cycle grant or deny pulse. A granted write-status or array write waits in a pending state until chip select rises. It then starts a self-timed write cycle of `WR_CYCLES` clock cycles. During that cycle the busy flag is set.

Two mechanisms protect the memory. The first is a pair of protect-range bits. They make no part, the upper quarter, the upper half or the whole of the array read-only. The second is a write-protect pin, active low. It blocks status writes only while the lock-enable bit (status bit 7) is 1. If the pin goes low while a granted status write is still pending, that write is cancelled. Once the timed cycle has begun, the pin has no further effect on it. A completed write cycle always clears the write-enable latch.

The state machine has four states. IDLE accepts commands. SR_WAIT holds a granted status write. ARR_WAIT holds a granted array write. BUSY runs the timed cycle. Transitions:
- IDLE→SR_WAIT on a granted status write.
- IDLE→ARR_WAIT on a granted array write.
- SR_WAIT→IDLE on abort by the pin.
- SR_WAIT→BUSY when chip select rises.
- ARR_WAIT→BUSY when chip select rises.
- BUSY→IDLE when the timer finishes.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and the latch output and busy are 0.
- R2: Command code 1 sets the write-enable latch and code 2 clears it. Each pulses grant for one cycle, and status bit 1 mirrors the latch.
- R3: A status write (code 3) or an array write (code 4) issued while the latch is 0 is denied and starts no write cycle.
- R4: A status write is denied when status bit 7 is 1 and `wp_n` is low. It is granted with `wp_n` low when bit 7 is 0.
- R5: If bit 7 is 1 and `wp_n` goes low while a granted status write still waits for chip select, the write is aborted. A deny pulse is given, no cycle starts, and the protection bits keep their value.
- R6: Once the write cycle has started, `wp_n` going low does not stop the new status value from being stored.
- R7: Busy (output and status bit 0) rises on the clock edge after `cs_n` is seen high in a waiting state and stays high for exactly `WR_CYCLES` cycles.
- R8: The write-enable latch is 0 after every completed write cycle.
- R9: Any command arriving while busy is denied and changes nothing.
- R10: Status bits 3:2 select the protected range: 00 none, 01 addresses whose two top bits are 11, 10 addresses whose top bit is 1, 11 all. An array write into a protected address is denied and starts no cycle. A write outside it is granted.
- R11: Data bits 3:2 and 7 of a status write are stored. Data bits 6:4 and 1:0 are discarded, and status bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the serial front end, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 3 | 1 set latch, 2 clear latch, 3 status write, 4 array write |
| cmd_data | input | 8 | Data byte for a status write |
| cmd_addr | input | ADDR_W | Byte address for an array write |
| status | output | 8 | {lock-enable, 000, protect[1:0], latch, busy} |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Self-timed write cycle in progress |
| grant | output | 1 | One-cycle pulse: command accepted |
| deny | output | 1 | One-cycle pulse: command refused or aborted |

## Verification
A wrong state register shows up in one of two ways. It can produce a grant or deny of the wrong kind on the cycle after the command. Or it can make busy rise at the wrong time, or fail to rise, one cycle after chip select goes high. A corrupted timer count shows as a busy window of the wrong length, and that becomes visible once the window ends. A protection value that was lost or stored by mistake (an abort that still commits, data bits that leak into the status) only shows on the next status read. It can also show as the grant or deny outcome of a later array write at a region boundary.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_ARR  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SR_WAIT,
        ST_ARR_WAIT,
        ST_BUSY
    } state_e;

    localparam int unsigned SR_WPEN_BIT = 7;
    localparam int unsigned SR_BP_LO    = 2;
endpackage

// File: rtl/sr_guard_region.sv
module sr_guard_region #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int unsigned MSB = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00:   locked = 1'b0;
            2'b01:   locked = addr[MSB] & addr[MSB-1];
            2'b10:   locked = addr[MSB];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_guard_timer.sv
module sr_guard_timer #(
    parameter int unsigned WR_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= LOAD;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned WR_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        status,
    output logic              wel,
    output logic              busy,
    output logic              grant,
    output logic              deny
);
    state_e     state, state_nx;
    logic [1:0] bp_q, bp_pend;
    logic       wpen_q, wpen_pend;
    logic       pend_is_sr;
    logic       pin_lock, region_lock, timer_go, timer_done;
    logic       sr_ok, arr_ok;
    op_e        op;

    assign op       = op_e'(cmd_op);
    assign pin_lock = wpen_q & ~wp_n;
    assign sr_ok    = wel & ~pin_lock;
    assign arr_ok   = wel & ~region_lock;

    sr_guard_region #(.ADDR_W(ADDR_W)) u_region (
        .bp     (bp_q),
        .addr   (cmd_addr),
        .locked (region_lock)
    );

    sr_guard_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_go),
        .done  (timer_done)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        timer_go = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && op == OP_WRSR && sr_ok)     state_nx = ST_SR_WAIT;
                else if (cmd_valid && op == OP_ARR && arr_ok) state_nx = ST_ARR_WAIT;
            end
            ST_SR_WAIT: begin
                if (pin_lock) state_nx = ST_IDLE;
                else if (cs_n) begin
                    state_nx = ST_BUSY;
                    timer_go = 1'b1;
                end
            end
            ST_ARR_WAIT: begin
                if (cs_n) begin
                    state_nx = ST_BUSY;
                    timer_go = 1'b1;
                end
            end
            ST_BUSY: begin
                if (timer_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and status fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel        <= 1'b0;
            grant      <= 1'b0;
            deny       <= 1'b0;
            bp_q       <= 2'b00;
            wpen_q     <= 1'b0;
            bp_pend    <= 2'b00;
            wpen_pend  <= 1'b0;
            pend_is_sr <= 1'b0;
        end else begin
            grant <= 1'b0;
            deny  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        unique case (op)
                            OP_WREN: begin
                                wel   <= 1'b1;
                                grant <= 1'b1;
                            end
                            OP_WRDI: begin
                                wel   <= 1'b0;
                                grant <= 1'b1;
                            end
                            OP_WRSR: begin
                                if (sr_ok) begin
                                    grant      <= 1'b1;
                                    pend_is_sr <= 1'b1;
                                    bp_pend    <= cmd_data[SR_BP_LO+1:SR_BP_LO];
                                    wpen_pend  <= cmd_data[SR_WPEN_BIT];
                                end else begin
                                    deny <= 1'b1;
                                end
                            end
                            OP_ARR: begin
                                if (arr_ok) begin
                                    grant      <= 1'b1;
                                    pend_is_sr <= 1'b0;
                                end else begin
                                    deny <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SR_WAIT: begin
                    if (pin_lock || cmd_valid) deny <= 1'b1;
                end
                ST_ARR_WAIT: begin
                    if (cmd_valid) deny <= 1'b1;
                end
                ST_BUSY: begin
                    if (cmd_valid) deny <= 1'b1;
                    if (timer_done) begin
                        wel <= 1'b0;
                        if (pend_is_sr) begin
                            bp_q   <= bp_pend;
                            wpen_q <= wpen_pend;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy   = (state == ST_BUSY);
    assign status = {wpen_q, 3'b000, bp_q, wel, busy};
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] status,
    input logic       wel,
    input logic       busy,
    input logic       grant,
    input logic       deny
);
    AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny)); // R2

    AST_NO_LATCH_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !wel && (cmd_op == 3'd3 || cmd_op == 3'd4)) |=> deny); // R3

    AST_START_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_n)); // R7

    AST_LATCH_CLEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R8

    AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (deny && !grant)); // R9

    AST_PROT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[7:2]) |-> $fell(busy)); // R6
endmodule

bind sr_guard sr_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .status    (status),
    .wel       (wel),
    .busy      (busy),
    .grant     (grant),
    .deny      (deny)
);

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
    localparam int unsigned ADDR_W    = 14;
    localparam int unsigned WR_CYCLES = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              wp_n = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [7:0]        cmd_data = 8'h00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        status;
    logic              wel, busy, grant, deny;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sr_guard #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_sr_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_addr(cmd_addr), .status(status), .wel(wel), .busy(busy),
        .grant(grant), .deny(deny)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drives one command; returns at the negedge where grant/deny is visible
    task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        cs_n      = 1'b0;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        cmd_addr  = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    // raise chip select and count the cycles busy stays high
    task automatic release_count(output int n);
        cs_n = 1'b1;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    task automatic set_status(input logic [7:0] d, input string tag);
        int n;
        issue(3'd1, 8'h00, '0);
        issue(3'd3, d, '0);
        check({tag, " grant"}, grant, 1);
        release_count(n);
        check({tag, " busy len"}, n, WR_CYCLES);
    endtask

    task automatic t_reset;
        check("R1 status", status, 8'h00);
        check("R1 wel", wel, 0);
        check("R1 busy", busy, 0);
    endtask

    task automatic t_latch;
        issue(3'd1, 8'h00, '0);
        check("R2 set grant", grant, 1);
        check("R2 status wel bit", status, 8'h02);
        issue(3'd2, 8'h00, '0);
        check("R2 clear grant", grant, 1);
        check("R2 wel cleared", wel, 0);
    endtask

    task automatic t_no_latch;
        int n;
        issue(3'd3, 8'h0C, '0);
        check("R3 sr deny", deny, 1);
        release_count(n);
        check("R3 sr no busy", n, 0);
        issue(3'd4, 8'h00, '0);
        check("R3 arr deny", deny, 1);
        release_count(n);
        check("R3 arr no busy", n, 0);
        check("R3 status", status, 8'h00);
    endtask

    task automatic t_pin_ignored;
        wp_n = 1'b0;
        set_status(8'h80, "R4 pin ignored/R7");
        check("R4 status stored", status, 8'h80);
        check("R8 wel cleared", wel, 0);
        issue(3'd1, 8'h00, '0);
        issue(3'd3, 8'h0C, '0);
        check("R4 locked deny", deny, 1);
        check("R4 status kept", status, 8'h82);
        issue(3'd2, 8'h00, '0);
        wp_n = 1'b1;
    endtask

    task automatic t_abort;
        int n;
        issue(3'd1, 8'h00, '0);
        issue(3'd3, 8'h8C, '0);
        check("R5 grant", grant, 1);
        wp_n = 1'b0;
        @(negedge clk);
        check("R5 abort deny", deny, 1);
        release_count(n);
        check("R5 no busy", n, 0);
        check("R5 protect kept", status & 8'hFC, 8'h80);
        wp_n = 1'b1;
    endtask

    task automatic t_started;
        int n;
        issue(3'd1, 8'h00, '0);
        issue(3'd3, 8'h8C, '0);
        check("R6 grant", grant, 1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R7 busy rise", busy, 1);
        check("R7 status busy bit", status[0], 1);
        wp_n = 1'b0;
        issue(3'd1, 8'h00, '0);
        check("R9 busy deny", deny, 1);
        check("R9 no grant", grant, 0);
        release_count(n);
        check("R6 status stored", status, 8'h8C);
        check("R9 wel still 0", wel, 0);
        wp_n = 1'b1;
    endtask

    task automatic region_try(input logic [ADDR_W-1:0] a, input int exp_grant, input string tag);
        int n;
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'h00, a);
        check({tag, " grant"}, grant, exp_grant);
        check({tag, " deny"}, deny, 1 - exp_grant);
        release_count(n);
        check({tag, " busy len"}, n, exp_grant ? WR_CYCLES : 0);
    endtask

    task automatic t_regions;
        region_try(14'h0000, 0, "R10 all");
        set_status(8'h04, "R10 set quarter");
        region_try(14'h3000, 0, "R10 quarter in");
        region_try(14'h2FFF, 1, "R10 quarter out");
        set_status(8'h08, "R10 set half");
        region_try(14'h2000, 0, "R10 half in");
        region_try(14'h1FFF, 1, "R10 half out");
        set_status(8'h00, "R10 set none");
        region_try(14'h3FFF, 1, "R10 none");
        check("R8 wel after array write", wel, 0);
    endtask

    task automatic t_layout;
        set_status(8'h73, "R11 set");
        check("R11 masked bits", status, 8'h00);
        set_status(8'hFF, "R11 set all");
        check("R11 kept bits", status, 8'h8C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_pin_ignored();
        t_abort();
        t_started();
        t_regions();
        t_layout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule